// File: doc/BRIEF.md
# Parallel-Bus ADC Frame Reader

This block collects one frame of conversion results from a multi-channel converter over a 16-bit bidirectional parallel bus. A single-cycle trigger starts a burst of active-low read strobes, one for each channel. The word on the bus is captured on the last low cycle of each strobe. Each captured word is sign-extended from the converter resolution to the bus width. It is then presented two ways. The first is a sequential stream with valid and sync strobes, suitable for a DMA FIFO. The second is a per-channel snapshot, qualified by its own valid pulse once the frame is complete.

The same bus also carries single register accesses to the converter. A write cycle turns the bus around, drives the write word and pulses an active-low write strobe. A read cycle pulses one read strobe and returns the full 16-bit bus word. Both end with a one-cycle done pulse. Commands are taken only while the reader is idle. Anything that arrives during an ongoing access is dropped.

Top module: `pbus_frame_reader`

## Requirements
- R1: After reset, `rdN` and `wrN` are 1, `dirIn` is 1, and `adcValid`, `adcSync`, `chValid` and `regDone` are 0.
- R2: A trigger sampled while idle produces exactly NUM_CH read strobes. Each strobe is low for the strobe length, and consecutive strobes are separated by max(HIGH_CYC,2) high cycles.
- R3: The bus word present on the last low cycle of strobe k is output on `adcData`. `adcValid` is high for exactly the one cycle in which `rdN` has just returned high.
- R4: Burst words keep bits RES_W-1..0 of the bus. Bit RES_W-1 is copied into every bit above it, and the bus bits above RES_W-1 are ignored.
- R5: `adcSync` is high together with `adcValid` on the channel 0 word, and on no other word.
- R6: Bits k*WORD_W upward of `chData` hold channel k of the frame. `chValid` pulses once per frame, in the same cycle as the valid of the last channel.
- R7: `dirIn` is 1 throughout a burst and a register read. It is 0 only during a register write cycle, while `wrN` is low and during the following high time.
- R8: `regWrReq` while idle drives `dbOut` with `regWrData` and pulls `wrN` low for the strobe length. After the high time, `regDone` pulses once.
- R9: `regRdReq` while idle pulses `rdN` once. The full unextended bus word from its last low cycle appears on `regRdData` when `regDone` pulses. No stream valid is produced.
- R10: A trigger, write request or read request that arrives while any access is in progress is dropped. It produces no extra strobe and no `regDone`.
- R11: Requests arriving in the same idle cycle are served by priority: trigger first, then write, then read. Only the winner runs.
- R12: The strobe length is `lowCycles`, captured when the access starts. Values 0 and 1 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Start a frame read (one-cycle pulse) |
| regWrReq | input | 1 | Request a register write cycle |
| regRdReq | input | 1 | Request a register read cycle |
| regWrData | input | WORD_W | Word driven on the bus during a write |
| lowCycles | input | CNT_W | Strobe low length in clocks (minimum 2) |
| dbIn | input | WORD_W | Bus value seen from the converter |
| dbOut | output | WORD_W | Value the block drives onto the bus |
| dirIn | output | 1 | Direction select: 1 input, 0 drive `dbOut` |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| adcData | output | WORD_W | Sequential sign-extended channel word |
| adcValid | output | 1 | Stream word valid |
| adcSync | output | 1 | Marks the channel 0 word |
| chData | output | NUM_CH*WORD_W | Per-channel snapshot, channel k at k*WORD_W |
| chValid | output | 1 | Snapshot complete pulse |
| regRdData | output | WORD_W | Result of the last register read |
| regDone | output | 1 | Register access finished |

## Verification
The bench builds the block with RES_W set to 14, a 16-bit bus, eight channels and HIGH_CYC set to 3. A resolution below the bus width makes the sign extension and the discarding of the upper bus bits observable. A high time above the minimum shows that the gap between strobes follows the parameter and is not a fixed two cycles. The strobe length is varied at run time between clamped and larger values. A converter model answers every falling read strobe with a distinct word, so misordered or missing channels show up in both the stream and the snapshot.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BURST_LO,
    S_BURST_HI,
    S_WR_LO,
    S_WR_HI,
    S_RR_LO,
    S_RR_HI
  } pfr_state_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic latchCh;   // capture burst word this cycle
    logic firstCh;   // current channel is channel 0
    logic lastCh;    // current channel is the last one
    logic latchReg;  // capture register read word this cycle
    logic loadWr;    // load write word for the bus
    logic cmdEnd;    // register access ends this cycle
  } pfr_strobe_t;

endpackage

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 8,
  parameter int HIGH_CYC = 2,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigger,
  input  logic            regWrReq,
  input  logic            regRdReq,
  input  logic [CNT_W-1:0] lowCycles,
  output logic            rdN,
  output logic            wrN,
  output logic            dirIn,
  output logic [CH_W-1:0] chIdx,
  output pfr_strobe_t     stb
);

  localparam int HIGH_EFF = (HIGH_CYC < 2) ? 2 : HIGH_CYC;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  pfr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] lowSat;
  logic             lowEnd;
  logic             highEnd;

  // Clamp the requested strobe length to the two-cycle minimum.
  assign lowSat  = (lowCycles < CNT_W'(2)) ? CNT_W'(2) : lowCycles;
  assign lowEnd  = (cnt == lowLen - CNT_W'(1));
  assign highEnd = (cnt == CNT_W'(HIGH_EFF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      chIdx  <= '0;
      lowLen <= CNT_W'(2);
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt   <= '0;
          chIdx <= '0;
          if (trigger) begin
            state  <= S_BURST_LO;
            lowLen <= lowSat;
          end else if (regWrReq) begin
            state  <= S_WR_LO;
            lowLen <= lowSat;
          end else if (regRdReq) begin
            state  <= S_RR_LO;
            lowLen <= lowSat;
          end
        end
        S_BURST_LO: begin
          if (lowEnd) begin
            state <= S_BURST_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_BURST_HI: begin
          if (highEnd) begin
            cnt <= '0;
            if (chIdx == LAST_CH) begin
              state <= S_IDLE;
            end else begin
              chIdx <= chIdx + CH_W'(1);
              state <= S_BURST_LO;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_WR_LO: begin
          if (lowEnd) begin
            state <= S_WR_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_RR_LO: begin
          if (lowEnd) begin
            state <= S_RR_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_WR_HI, S_RR_HI: begin
          if (highEnd) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Pin decode from the state register.
  assign rdN   = !((state == S_BURST_LO) || (state == S_RR_LO));
  assign wrN   = !(state == S_WR_LO);
  assign dirIn = !((state == S_WR_LO) || (state == S_WR_HI));

  always_comb begin
    stb          = '0;
    stb.latchCh  = (state == S_BURST_LO) && lowEnd;
    stb.firstCh  = (chIdx == '0);
    stb.lastCh   = (chIdx == LAST_CH);
    stb.latchReg = (state == S_RR_LO) && lowEnd;
    stb.loadWr   = (state == S_IDLE) && !trigger && regWrReq;
    stb.cmdEnd   = ((state == S_WR_HI) || (state == S_RR_HI)) && highEnd;
  end

  // R2 / R12: a read strobe is never shorter than two cycles.
  p_read_low_min_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |=> !rdN);

  // R2: the gap between read strobes is at least two cycles.
  p_read_high_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |=> rdN);

  // R8: a write strobe is never shorter than two cycles.
  p_write_low_min_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |=> !wrN);

endmodule

// File: rtl/pfr_datapath.sv
module pfr_datapath
  import pfr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RES_W  = 16,
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pfr_strobe_t              stb,
  input  logic [CH_W-1:0]          chIdx,
  input  logic [WORD_W-1:0]        dbIn,
  input  logic [WORD_W-1:0]        regWrData,
  output logic [WORD_W-1:0]        dbOut,
  output logic [WORD_W-1:0]        adcData,
  output logic                     adcValid,
  output logic                     adcSync,
  output logic [NUM_CH*WORD_W-1:0] chData,
  output logic                     chValid,
  output logic [WORD_W-1:0]        regRdData,
  output logic                     regDone
);

  logic [WORD_W-1:0] extWord;

  // Sign extension chosen by resolution.
  generate
    if (RES_W < WORD_W) begin : g_ext
      assign extWord = {{(WORD_W - RES_W){dbIn[RES_W-1]}}, dbIn[RES_W-1:0]};
    end else begin : g_full
      assign extWord = dbIn;
    end
  endgenerate

  // Sequential stream.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcData  <= '0;
      adcValid <= 1'b0;
      adcSync  <= 1'b0;
      chValid  <= 1'b0;
    end else begin
      adcValid <= stb.latchCh;
      adcSync  <= stb.latchCh && stb.firstCh;
      chValid  <= stb.latchCh && stb.lastCh;
      if (stb.latchCh) adcData <= extWord;
    end
  end

  // Per-channel snapshot registers.
  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [WORD_W-1:0] chReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                     chReg <= '0;
        else if (stb.latchCh && (chIdx == CH_W'(k)))   chReg <= extWord;
      end
      assign chData[k*WORD_W +: WORD_W] = chReg;
    end
  endgenerate

  // Register access path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbOut     <= '0;
      regRdData <= '0;
      regDone   <= 1'b0;
    end else begin
      regDone <= stb.cmdEnd;
      if (stb.loadWr)   dbOut     <= regWrData;
      if (stb.latchReg) regRdData <= dbIn;
    end
  end

  // R5: sync only accompanies a valid word.
  p_sync_needs_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcSync |-> adcValid);

  // R6: the snapshot pulse coincides with the last stream word.
  p_snapshot_with_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    chValid |-> adcValid);

endmodule

// File: rtl/pbus_frame_reader.sv
module pbus_frame_reader
  import pfr_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int RES_W    = 16,
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 8,
  parameter int HIGH_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     trigger,
  input  logic                     regWrReq,
  input  logic                     regRdReq,
  input  logic [WORD_W-1:0]        regWrData,
  input  logic [CNT_W-1:0]         lowCycles,
  input  logic [WORD_W-1:0]        dbIn,
  output logic [WORD_W-1:0]        dbOut,
  output logic                     dirIn,
  output logic                     rdN,
  output logic                     wrN,
  output logic [WORD_W-1:0]        adcData,
  output logic                     adcValid,
  output logic                     adcSync,
  output logic [NUM_CH*WORD_W-1:0] chData,
  output logic                     chValid,
  output logic [WORD_W-1:0]        regRdData,
  output logic                     regDone
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  pfr_strobe_t     stb;
  logic [CH_W-1:0] chIdx;

  pfr_ctrl #(
    .NUM_CH  (NUM_CH),
    .CNT_W   (CNT_W),
    .HIGH_CYC(HIGH_CYC)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .regWrReq (regWrReq),
    .regRdReq (regRdReq),
    .lowCycles(lowCycles),
    .rdN      (rdN),
    .wrN      (wrN),
    .dirIn    (dirIn),
    .chIdx    (chIdx),
    .stb      (stb)
  );

  pfr_datapath #(
    .WORD_W(WORD_W),
    .RES_W (RES_W),
    .NUM_CH(NUM_CH)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .chIdx    (chIdx),
    .dbIn     (dbIn),
    .regWrData(regWrData),
    .dbOut    (dbOut),
    .adcData  (adcData),
    .adcValid (adcValid),
    .adcSync  (adcSync),
    .chData   (chData),
    .chValid  (chValid),
    .regRdData(regRdData),
    .regDone  (regDone)
  );

  // R3: a stream word appears exactly as the read strobe returns high.
  p_valid_on_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    adcValid |-> $rose(rdN));

  // R7: the bus is never driven while a read strobe is low.
  p_dir_in_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> dirIn);

  // R8: the write strobe only falls with the bus already driven.
  p_dir_out_on_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> !dirIn);

endmodule

// File: tb/pbus_frame_reader_tb_top.sv
module pbus_frame_reader_tb_top;

  localparam int WORD_W   = 16;
  localparam int RES_W    = 14;
  localparam int NUM_CH   = 8;
  localparam int CNT_W    = 8;
  localparam int HIGH_CYC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic regWrReq = 1'b0;
  logic regRdReq = 1'b0;
  logic [WORD_W-1:0] regWrData = '0;
  logic [CNT_W-1:0]  lowCycles = CNT_W'(2);
  logic [WORD_W-1:0] dbIn = '0;
  logic [WORD_W-1:0] dbOut;
  logic dirIn, rdN, wrN;
  logic [WORD_W-1:0] adcData;
  logic adcValid, adcSync, chValid, regDone;
  logic [NUM_CH*WORD_W-1:0] chData;
  logic [WORD_W-1:0] regRdData;

  always #10 clk = ~clk;

  pbus_frame_reader #(
    .WORD_W(WORD_W), .RES_W(RES_W), .NUM_CH(NUM_CH),
    .CNT_W(CNT_W), .HIGH_CYC(HIGH_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .regWrReq(regWrReq),
    .regRdReq(regRdReq), .regWrData(regWrData), .lowCycles(lowCycles),
    .dbIn(dbIn), .dbOut(dbOut), .dirIn(dirIn), .rdN(rdN), .wrN(wrN),
    .adcData(adcData), .adcValid(adcValid), .adcSync(adcSync),
    .chData(chData), .chValid(chValid), .regRdData(regRdData),
    .regDone(regDone)
  );

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] sampleOf(input int k);
    return WORD_W'(k * 16'h2469 + 16'h03A5);
  endfunction

  function automatic logic [WORD_W-1:0] extOf(input logic [WORD_W-1:0] w);
    return {{(WORD_W-RES_W){w[RES_W-1]}}, w[RES_W-1:0]};
  endfunction

  // Converter model: a new word on every falling read strobe.
  bit regMode = 0;
  logic [WORD_W-1:0] regWord = '0;
  int modelIdx = 0;
  always @(negedge rdN) begin
    if (regMode) dbIn = regWord;
    else begin
      dbIn = sampleOf(modelIdx);
      modelIdx++;
    end
  end

  // Monitor, sampling away from the active edge.
  int strobes, lowRun, highRun, minLow, maxLow, minHigh, dirErr;
  int vCnt, timingErr, chvCnt, chvAt, wrLow, wrDirErr, doneCnt;
  logic [WORD_W-1:0] got [NUM_CH];
  bit syncs [NUM_CH];
  logic [NUM_CH*WORD_W-1:0] snap;
  logic [WORD_W-1:0] wrSeen, rdBack;
  logic prevRdN = 1'b1;

  task automatic clearStats();
    strobes = 0; lowRun = 0; highRun = 0; minLow = 999; maxLow = 0;
    minHigh = 999; dirErr = 0; vCnt = 0; timingErr = 0; chvCnt = 0;
    chvAt = -1; wrLow = 0; wrDirErr = 0; doneCnt = 0; modelIdx = 0;
    snap = '0; wrSeen = '0; rdBack = '0;
    for (int i = 0; i < NUM_CH; i++) begin got[i] = '0; syncs[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!rdN) begin
        if (lowRun == 0 && strobes > 0 && highRun < minHigh) minHigh = highRun;
        lowRun++;
        highRun = 0;
        if (!dirIn) dirErr++;
      end else begin
        if (lowRun > 0) begin
          strobes++;
          if (lowRun < minLow) minLow = lowRun;
          if (lowRun > maxLow) maxLow = lowRun;
          lowRun = 0;
        end
        highRun++;
      end
      if (adcValid) begin
        if (vCnt < NUM_CH) begin got[vCnt] = adcData; syncs[vCnt] = adcSync; end
        if (prevRdN !== 1'b0 || rdN !== 1'b1) timingErr++;
        vCnt++;
      end
      if (chValid) begin chvCnt++; snap = chData; chvAt = vCnt; end
      if (!wrN) begin wrLow++; wrSeen = dbOut; if (dirIn) wrDirErr++; end
      if (regDone) begin doneCnt++; rdBack = regRdData; end
      prevRdN = rdN;
    end
  end

  task automatic pulse(input bit t, input bit w, input bit r);
    @(negedge clk);
    trigger = t; regWrReq = w; regRdReq = r;
    @(negedge clk);
    trigger = 0; regWrReq = 0; regRdReq = 0;
  endtask

  task automatic testReset();
    check(rdN === 1'b1 && wrN === 1'b1, "R1 strobes idle", {rdN, wrN}, 2'b11);
    check(dirIn === 1'b1, "R1 direction input", dirIn, 1);
    check({adcValid, adcSync, chValid, regDone} === 4'b0, "R1 pulses low",
          {adcValid, adcSync, chValid, regDone}, 0);
  endtask

  task automatic testBurst(input int cfg, input int expLow);
    clearStats();
    regMode = 0;
    lowCycles = CNT_W'(cfg);
    pulse(1, 0, 0);
    repeat (NUM_CH * (expLow + HIGH_CYC) + 10) @(negedge clk);
    check(strobes == NUM_CH, "R2 strobe count", strobes, NUM_CH);
    check(minLow == expLow && maxLow == expLow, "R12 strobe length", maxLow, expLow);
    check(minHigh == HIGH_CYC, "R2 gap length", minHigh, HIGH_CYC);
    check(vCnt == NUM_CH, "R3 word count", vCnt, NUM_CH);
    check(timingErr == 0, "R3 valid timing", timingErr, 0);
    for (int k = 0; k < NUM_CH; k++) begin
      check(got[k] === extOf(sampleOf(k)), $sformatf("R4 channel %0d word", k),
            got[k], extOf(sampleOf(k)));
      check(syncs[k] == (k == 0), $sformatf("R5 sync on word %0d", k), syncs[k], k == 0);
      check(snap[k*WORD_W +: WORD_W] === extOf(sampleOf(k)),
            $sformatf("R6 snapshot channel %0d", k), snap[k*WORD_W +: WORD_W],
            extOf(sampleOf(k)));
    end
    check(chvCnt == 1 && chvAt == NUM_CH, "R6 snapshot pulse", chvAt, NUM_CH);
    check(dirErr == 0 && wrLow == 0, "R7 bus stays input", dirErr, 0);
  endtask

  task automatic testBusyDrop();
    clearStats();
    regMode = 0;
    lowCycles = CNT_W'(3);
    pulse(1, 0, 0);
    repeat (8) @(negedge clk);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    repeat (NUM_CH * (3 + HIGH_CYC) + 20) @(negedge clk);
    check(strobes == NUM_CH, "R10 no extra strobes", strobes, NUM_CH);
    check(wrLow == 0 && doneCnt == 0, "R10 commands dropped", wrLow + doneCnt, 0);
    check(vCnt == NUM_CH && chvCnt == 1, "R10 one frame", vCnt, NUM_CH);
  endtask

  task automatic testWrite();
    clearStats();
    lowCycles = CNT_W'(4);
    regWrData = 16'hA5C3;
    pulse(0, 1, 0);
    repeat (20) @(negedge clk);
    check(wrLow == 4, "R8 write strobe length", wrLow, 4);
    check(wrSeen === 16'hA5C3, "R8 write word", wrSeen, 16'hA5C3);
    check(wrDirErr == 0, "R7 driven during write", wrDirErr, 0);
    check(doneCnt == 1 && strobes == 0, "R8 done pulse", doneCnt, 1);
    check(dirIn === 1'b1, "R7 direction back to input", dirIn, 1);
  endtask

  task automatic testRead();
    clearStats();
    regMode = 1;
    regWord = 16'h8123;
    lowCycles = CNT_W'(2);
    pulse(0, 0, 1);
    repeat (20) @(negedge clk);
    check(strobes == 1 && minLow == 2, "R9 one read strobe", strobes, 1);
    check(doneCnt == 1 && rdBack === 16'h8123, "R9 read word", rdBack, 16'h8123);
    check(vCnt == 0, "R9 no stream word", vCnt, 0);
    regMode = 0;
  endtask

  task automatic testPriority();
    clearStats();
    lowCycles = CNT_W'(2);
    pulse(1, 1, 1);
    repeat (NUM_CH * (2 + HIGH_CYC) + 15) @(negedge clk);
    check(strobes == NUM_CH && vCnt == NUM_CH, "R11 trigger wins", strobes, NUM_CH);
    check(wrLow == 0 && doneCnt == 0, "R11 others dropped", wrLow + doneCnt, 0);
    clearStats();
    regWrData = 16'h0F0F;
    pulse(0, 1, 1);
    repeat (20) @(negedge clk);
    check(wrLow == 2 && strobes == 0, "R11 write over read", strobes, 0);
    check(doneCnt == 1, "R11 single done", doneCnt, 1);
  endtask

  initial begin
    clearStats();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBurst(3, 3);
    testBurst(0, 2);
    testBurst(1, 2);
    testBurst(5, 5);
    testBusyDrop();
    testWrite();
    testRead();
    testPriority();
    finished = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog R2: actual hung expected completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule